// File: doc/BRIEF.md
# Frame-Slot Operand Pairing Unit

This unit brings together the two operands of a two-input instruction in a dataflow execution pipeline. Each token that arrives carries a continuation, which is a frame base and an instruction index, along with a data value and a flag that marks the input arc (left or right). The unit fetches the instruction word named by the index from an external synchronous instruction store. From that word it takes an opcode, a slot offset and two destination displacements. It then checks one presence bit at the address frame base plus offset. No associative lookup is involved.

If the slot is vacant, the value is stored there and the token is absorbed. If the slot is occupied, the stored value is taken out, the slot becomes vacant, and the operand pair leaves the unit together with the opcode and the two successor continuations. Single-input opcodes skip the slot entirely and leave at once. Both the token input and the pair output use valid/ready handshakes. A stalled output holds back only the tokens that would produce output.

Top module: `token_matcher`

## Requirements
- R1: After reset every slot is vacant, `out_valid` is low and `in_ready` is high.
- R2: The slot address is `in_fp` plus the zero-extended offset, modulo 2^FP_W. Two tokens whose sums are equal share a slot, even when their frame bases and instruction indices differ.
- R3: A two-input token that finds its slot vacant stores its value, marks the slot occupied and produces no output.
- R4: A two-input token that finds its slot occupied produces one pair carrying the stored value and leaves the slot vacant, so the next token for that slot is stored again.
- R5: In a pair, the arriving value goes to `out_left` when the arriving port flag is 0 and to `out_right` when it is 1. The stored value goes to the other side.
- R6: An opcode with its top bit set is single-input. It fires with `out_left` equal to its value and `out_right` zero, and it neither reads nor changes any slot.
- R7: The instruction word is laid out as opcode [17:14], offset [13:10], disp0 [9:6], port0 [5], disp1 [4:1], port1 [0]. The outputs are `out_dst0_ip = ip + disp0` and `out_dst1_ip = ip + disp1`, both modulo 2^IP_W, with each port bit copied to its destination. `out_fp` and `out_opc` pass through unchanged.
- R8: While `out_valid` is high and `out_ready` is low, every output stays stable. No fired token is lost or duplicated.
- R9: Tokens for the same slot that arrive on consecutive cycles are resolved strictly in arrival order, with no idle cycle between them. Pairs leave in the order their second tokens arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Token offered |
| in_ready | output | 1 | Token taken on this edge |
| in_fp | input | FP_W | Frame base of the token |
| in_ip | input | IP_W | Instruction index of the token |
| in_port | input | 1 | Arc flag, 0 left, 1 right |
| in_val | input | VAL_W | Token value |
| ins_addr | output | IP_W | Instruction store address, read synchronously |
| ins_word | input | IW | Instruction word returned one cycle after the address |
| out_valid | output | 1 | Enabled pair available |
| out_ready | input | 1 | Pair consumed on this edge |
| out_opc | output | OPC_W | Opcode of the fired instruction |
| out_fp | output | FP_W | Frame base of the fired instruction |
| out_left | output | VAL_W | Left operand |
| out_right | output | VAL_W | Right operand |
| out_dst0_ip | output | IP_W | First successor instruction index |
| out_dst0_port | output | 1 | First successor arc flag |
| out_dst1_ip | output | IP_W | Second successor instruction index |
| out_dst1_port | output | 1 | Second successor arc flag |

## Verification
The hazardous overlap is a token performing its slot read-modify-write while the pair stage holds an earlier pair under back-pressure. A storing token must still go through, and a pairing token must wait without overwriting the held partner value. The bench provokes this by driving `out_ready` randomly while sending dense traffic over a handful of frames and indices, so the same slot is hit back to back. A behavioural slot map follows every accepted token. Each delivered pair is compared to the front of an expected queue, and every stalled cycle is checked for unchanged outputs.

// File: rtl/token_matcher.sv
module token_matcher #(
  parameter int FP_W   = 8,
  parameter int IP_W   = 8,
  parameter int VAL_W  = 16,
  parameter int OPC_W  = 4,
  parameter int OFF_W  = 4,
  parameter int DISP_W = 4,
  localparam int IW    = OPC_W + OFF_W + 2 * (DISP_W + 1),
  localparam int DEPTH = 1 << FP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FP_W-1:0]   in_fp,
  input  logic [IP_W-1:0]   in_ip,
  input  logic              in_port,
  input  logic [VAL_W-1:0]  in_val,
  output logic [IP_W-1:0]   ins_addr,
  input  logic [IW-1:0]     ins_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OPC_W-1:0]  out_opc,
  output logic [FP_W-1:0]   out_fp,
  output logic [VAL_W-1:0]  out_left,
  output logic [VAL_W-1:0]  out_right,
  output logic [IP_W-1:0]   out_dst0_ip,
  output logic              out_dst0_port,
  output logic [IP_W-1:0]   out_dst1_ip,
  output logic              out_dst1_port
);

  logic              s1_v, s1_port;
  logic [FP_W-1:0]   s1_fp;
  logic [IP_W-1:0]   s1_ip;
  logic [VAL_W-1:0]  s1_val;

  logic [OPC_W-1:0]  opc;
  logic [OFF_W-1:0]  off;
  logic [DISP_W-1:0] d0, d1;
  logic              p0, p1, mono, full, fire, s1_adv;
  logic [FP_W-1:0]   slot;

  assign opc  = ins_word[IW-1 -: OPC_W];
  assign off  = ins_word[2*(DISP_W+1) +: OFF_W];
  assign d0   = ins_word[DISP_W+2 +: DISP_W];
  assign p0   = ins_word[DISP_W+1];
  assign d1   = ins_word[1 +: DISP_W];
  assign p1   = ins_word[0];
  assign mono = opc[OPC_W-1];

  logic [DEPTH-1:0]  pres;
  logic [VAL_W-1:0]  mem [DEPTH];
  logic [VAL_W-1:0]  rd_q;

  logic              s2_v, s2_mono, s2_port, s2_p0, s2_p1;
  logic [OPC_W-1:0]  s2_opc;
  logic [FP_W-1:0]   s2_fp;
  logic [VAL_W-1:0]  s2_val;
  logic [IP_W-1:0]   s2_d0, s2_d1;

  assign slot     = s1_fp + FP_W'(off);
  assign full     = pres[slot];
  assign fire     = mono || full;
  assign s1_adv   = s1_v && (!fire || !s2_v || out_ready);
  assign in_ready = !s1_v || s1_adv;
  assign ins_addr = in_ready ? in_ip : s1_ip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_port <= 1'b0;
      s1_fp   <= '0;
      s1_ip   <= '0;
      s1_val  <= '0;
    end else if (in_ready) begin
      s1_v    <= in_valid;
      s1_port <= in_port;
      s1_fp   <= in_fp;
      s1_ip   <= in_ip;
      s1_val  <= in_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pres <= '0;
    else if (s1_adv && !mono) pres[slot] <= !full;
  end

  always_ff @(posedge clk) begin
    if (s1_adv && !mono) begin
      if (full) rd_q <= mem[slot];
      else mem[slot] <= s1_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v <= 1'b0;
      s2_mono <= 1'b0; s2_port <= 1'b0; s2_p0 <= 1'b0; s2_p1 <= 1'b0;
      s2_opc <= '0; s2_fp <= '0; s2_val <= '0; s2_d0 <= '0; s2_d1 <= '0;
    end else if (s1_adv && fire) begin
      s2_v    <= 1'b1;
      s2_mono <= mono;
      s2_port <= s1_port;
      s2_opc  <= opc;
      s2_fp   <= s1_fp;
      s2_val  <= s1_val;
      s2_d0   <= s1_ip + IP_W'(d0);
      s2_p0   <= p0;
      s2_d1   <= s1_ip + IP_W'(d1);
      s2_p1   <= p1;
    end else if (out_ready) begin
      s2_v <= 1'b0;
    end
  end

  assign out_valid     = s2_v;
  assign out_opc       = s2_opc;
  assign out_fp        = s2_fp;
  assign out_left      = s2_mono ? s2_val : (s2_port ? rd_q : s2_val);
  assign out_right     = s2_mono ? '0     : (s2_port ? s2_val : rd_q);
  assign out_dst0_ip   = s2_d0;
  assign out_dst0_port = s2_p0;
  assign out_dst1_ip   = s2_d1;
  assign out_dst1_port = s2_p1;

  a_r3_park_sets: assert property (@(posedge clk) disable iff (!rst_n)
    s1_adv && !mono && !full |=> pres[$past(slot)]);

  a_r3_park_silent: assert property (@(posedge clk) disable iff (!rst_n)
    s1_adv && !fire && (!s2_v || out_ready) |=> !out_valid);

  a_r4_pair_clears: assert property (@(posedge clk) disable iff (!rst_n)
    s1_adv && !mono && full |=> !pres[$past(slot)] && out_valid);

  a_r6_mono_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    s1_adv && mono |=> $stable(pres));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_left) && $stable(out_right)
      && $stable(out_dst0_ip) && $stable(out_dst1_ip) && $stable(out_opc));

  a_r9_accept_lands: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_v && s1_ip == $past(in_ip));

endmodule

// File: tb/token_matcher_test.sv
module token_matcher_test;
  localparam int IW = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_port = 1'b0, out_ready = 1'b0;
  logic [7:0]  in_fp = '0, in_ip = '0;
  logic [15:0] in_val = '0;
  logic        in_ready, out_valid, out_dst0_port, out_dst1_port;
  logic [7:0]  ins_addr, out_fp, out_dst0_ip, out_dst1_ip;
  logic [IW-1:0] ins_word;
  logic [3:0]  out_opc;
  logic [15:0] out_left, out_right;

  always #2.5 clk = ~clk;

  token_matcher uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fp(in_fp), .in_ip(in_ip), .in_port(in_port), .in_val(in_val),
    .ins_addr(ins_addr), .ins_word(ins_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_opc(out_opc),
    .out_fp(out_fp), .out_left(out_left), .out_right(out_right),
    .out_dst0_ip(out_dst0_ip), .out_dst0_port(out_dst0_port),
    .out_dst1_ip(out_dst1_ip), .out_dst1_port(out_dst1_port));

  function automatic logic [IW-1:0] rom(input logic [7:0] ip);
    logic [3:0] opc;
    opc = {(ip % 5) == 0, ip[2:0]};
    return {opc, ip[3:0] ^ ip[7:4], ip[3:0] + 4'd1, ip[0], ip[5:2], ip[1]};
  endfunction

  always_ff @(posedge clk) ins_word <= rom(ins_addr);

  int total = 0, bad = 0;
  int ready_mode = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]  opc;
    logic [15:0] left;
    logic [15:0] right;
    logic [7:0]  fp;
    logic [7:0]  d0;
    logic        p0;
    logic [7:0]  d1;
    logic        p1;
    logic        mono;
  } exp_t;

  exp_t        expq[$];
  bit          mpres[256];
  logic [15:0] mval[256];

  function automatic exp_t make(input logic [7:0] fp, input logic [7:0] ip,
                                input logic [15:0] l, input logic [15:0] r, input logic m);
    exp_t e;
    logic [IW-1:0] w;
    w = rom(ip);
    e.opc = w[17:14]; e.left = l; e.right = r; e.fp = fp;
    e.d0 = ip + 8'(w[9:6]); e.p0 = w[5];
    e.d1 = ip + 8'(w[4:1]); e.p1 = w[0];
    e.mono = m;
    return e;
  endfunction

  task automatic model_accept(input logic [7:0] fp, input logic [7:0] ip,
                              input logic port, input logic [15:0] v);
    logic [IW-1:0] w;
    logic [7:0] s;
    w = rom(ip);
    if (w[17]) expq.push_back(make(fp, ip, v, 16'h0, 1'b1));
    else begin
      s = fp + {4'h0, w[13:10]};
      if (!mpres[s]) begin
        mpres[s] = 1'b1;
        mval[s] = v;
      end else begin
        mpres[s] = 1'b0;
        if (port) expq.push_back(make(fp, ip, mval[s], v, 1'b0));
        else      expq.push_back(make(fp, ip, v, mval[s], 1'b0));
      end
    end
  endtask

  function automatic logic [63:0] pack_out();
    return {out_opc, out_left, out_right, out_fp, out_dst0_ip, out_dst0_port,
            out_dst1_ip, out_dst1_port};
  endfunction

  logic        prev_stall = 1'b0;
  logic [63:0] prev_out = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        chk(out_valid && pack_out() == prev_out, "R8 stalled output changed",
            pack_out(), prev_out);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(1'b0, "R3 unexpected output", pack_out(), 64'h0);
        else begin
          exp_t e;
          logic [63:0] ev;
          e = expq.pop_front();
          ev = {e.opc, e.left, e.right, e.fp, e.d0, e.p0, e.d1, e.p1};
          if (e.mono) chk(pack_out() == ev, "R6 R7 single-input fire", pack_out(), ev);
          else        chk(pack_out() == ev, "R2 R4 R5 R7 pair", pack_out(), ev);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_out   = pack_out();
      if (in_valid && in_ready) model_accept(in_fp, in_ip, in_port, in_val);
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = (ready_mode == 0) ? 1'b1 : 1'($urandom % 3 != 0);
    end
  end

  task automatic send(input logic [7:0] fp, input logic [7:0] ip,
                      input logic port, input logic [15:0] v);
    in_valid = 1'b1; in_fp = fp; in_ip = ip; in_port = port; in_val = v;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mpres[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R1 out_valid after reset", 64'(out_valid), 64'h0);
    chk(in_ready, "R1 in_ready after reset", 64'(in_ready), 64'h1);
    @(posedge clk); #1;

    // R3: vacant slot 8 absorbs the token
    send(8'd3, 8'h27, 1'b0, 16'h1111);
    idle(4);
    @(negedge clk);
    chk(!out_valid, "R3 stored token produced output", 64'(out_valid), 64'h0);
    @(posedge clk); #1;
    // R2: different frame and index, same slot 8
    send(8'd8, 8'h11, 1'b1, 16'h2222);
    idle(4);
    // R6: single-input between two halves of a pair on slot 7
    send(8'd2, 8'h27, 1'b0, 16'h000A);
    send(8'd2, 8'h05, 1'b0, 16'h000B);
    send(8'd2, 8'h27, 1'b1, 16'h000C);
    idle(4);
    // R9: back-to-back tokens on one slot
    send(8'd5, 8'h27, 1'b0, 16'h0101);
    send(8'd5, 8'h27, 1'b1, 16'h0202);
    send(8'd5, 8'h27, 1'b1, 16'h0303);
    send(8'd5, 8'h27, 1'b0, 16'h0404);
    idle(4);
    // R2: frame base wraps into slot 3
    send(8'hFE, 8'h27, 1'b0, 16'h5A5A);
    send(8'd3, 8'h11, 1'b0, 16'hA5A5);
    idle(4);

    // R8 R9: random back-pressure, dense slot reuse
    ready_mode = 1;
    for (int k = 0; k < 800; k++) begin
      send(8'($urandom % 4), 8'($urandom % 32), 1'($urandom % 2), 16'($urandom));
      if ($urandom % 4 == 0) idle(1);
    end
    ready_mode = 0;
    idle(20);
    @(negedge clk);
    chk(expq.size() == 0, "R8 R9 fired tokens all delivered", 64'(expq.size()), 64'h0);
    chk(!out_valid, "R8 output drained", 64'(out_valid), 64'h0);
    finish_run();
  end
endmodule